// File: doc/BRIEF.md
# 16-bit Carry-Chained Add/Subtract Flag Unit

This unit performs the arithmetic step of the 16-bit register-pair add-with-carry and subtract-with-borrow operations. It also performs an 8-bit two's-complement negate of the byte accumulator. For every operation it produces a full flag byte. The caller presents an operation code, both accumulators, the 16-bit operand and the current flag byte, then pulses `start`. One clock edge later the results, the new flag byte and a one-cycle `done` pulse appear on registered outputs.

The 16-bit operations take the incoming carry from bit 0 of the flag byte and ignore the other incoming flag bits. Their half-carry is the carry or borrow out of bit 11, which is the boundary at bit 12 of the upper byte's low nibble. Their sign bit is reported only when the 16-bit result is non-zero. Negate ignores the incoming flag byte entirely.

Top module: `cc_flag_unit`

## Requirements
- R1: Op code 0 (add) gives `res_wide` = (acc_wide + opnd_wide + flags_in[0]) mod 2^16, with `res_narrow` = acc_narrow unchanged.
- R2: Op code 1 (subtract) gives `res_wide` = (acc_wide − opnd_wide − flags_in[0]) mod 2^16, with `res_narrow` = acc_narrow unchanged.
- R3: For ops 0 and 1, carry (flag bit 0) is set when the unbounded add exceeds 0xFFFF, or when the unbounded subtract is below zero.
- R4: For ops 0 and 1, zero (flag bit 6) is set when the 16-bit result is 0x0000. Sign (flag bit 7) equals result bit 15 when the result is non-zero, and is 0 otherwise.
- R5: For ops 0 and 1, half-carry (flag bit 4) equals bit 12 of acc_wide XOR opnd_wide XOR result.
- R6: For ops 0 and 1, overflow (flag bit 2) is set when the signed 16-bit result of the operation, including the carry-in, falls outside −32768..32767.
- R7: Subtract flag (flag bit 1) is 1 after op 1 and op 2, and 0 after op 0.
- R8: Op code 2 (negate) gives `res_narrow` = (0 − acc_narrow) mod 256, with `res_wide` = acc_wide unchanged. Its flags are: sign = result bit 7, zero = result is 0, half-carry = (acc_narrow & 0x0F) ≠ 0, overflow = acc_narrow is 0x80, carry = acc_narrow ≠ 0. The incoming flag byte is ignored.
- R9: Flag bits 3 and 5 of `flags_out` are always 0.
- R10: Results, flags and `done` are registered. They update on the first rising clock edge where `start` is high, and `done` is high for exactly the cycle after that edge. After reset all outputs are 0.
- R11: Without `start`, all outputs keep their values whatever the other inputs do, and `done` stays low.
- R12: Op code 3 passes both accumulators through unchanged, and outputs flags_in with bits 3 and 5 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation strobe |
| op | input | 2 | Operation: 0 add, 1 subtract, 2 negate, 3 pass |
| acc_wide | input | 16 | 16-bit accumulator pair |
| opnd_wide | input | 16 | 16-bit operand pair |
| acc_narrow | input | 8 | 8-bit accumulator |
| flags_in | input | 8 | Incoming flag byte, carry in bit 0 |
| res_wide | output | 16 | Registered 16-bit result |
| res_narrow | output | 8 | Registered 8-bit result |
| flags_out | output | 8 | Registered new flag byte |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The hardest flags to reach are the signed overflows that coincide with a zero result. One example is add 0x8000 + 0x8000, which wraps to 0x0000 with carry and overflow set and the sign suppressed. Another is subtract where the incoming borrow alone moves the result across the 0x8000/0x7FFF boundary. Random operands almost never land on these cases. The stimulus therefore sweeps every pairing of 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF, with carry-in both clear and set, for both wide operations. It also negates 0x00, 0x80 and nibble-boundary bytes. Random traffic is then issued back-to-back and with idle gaps, with scrambled upper flag bits, so that pass-through and hold behaviour are exercised as well.

// File: rtl/cc_flag_pkg.sv
package cc_flag_pkg;

    // Flag byte bit positions
    localparam int FLAG_C  = 0;
    localparam int FLAG_N  = 1;
    localparam int FLAG_PV = 2;
    localparam int FLAG_X3 = 3;
    localparam int FLAG_H  = 4;
    localparam int FLAG_X5 = 5;
    localparam int FLAG_Z  = 6;
    localparam int FLAG_S  = 7;

    typedef enum logic [1:0] {
        OP_ADC  = 2'd0,
        OP_SBC  = 2'd1,
        OP_NEG  = 2'd2,
        OP_PASS = 2'd3
    } op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic x5;
        logic h;
        logic x3;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    function automatic flags_t make_flags(input logic s, input logic z, input logic h,
                                          input logic pv, input logic n, input logic c);
        flags_t f;
        f.s  = s;
        f.z  = z;
        f.x5 = 1'b0;
        f.h  = h;
        f.x3 = 1'b0;
        f.pv = pv;
        f.n  = n;
        f.c  = c;
        return f;
    endfunction

    function automatic flags_t clean_flags(input logic [7:0] raw);
        flags_t f;
        f    = flags_t'(raw);
        f.x3 = 1'b0;
        f.x5 = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/wide_addsub.sv
module wide_addsub
    import cc_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output flags_t       flags
);
    localparam int XW  = W + 1;
    localparam int MSB = W - 1;
    localparam int HB  = W - 4;

    logic [XW-1:0] ext_a;
    logic [XW-1:0] ext_b;
    logic [XW-1:0] ext_c;
    logic [XW-1:0] wide;
    logic [W-1:0]  mix;
    logic          zero;
    logic          sign;
    logic          ovf;

    always_comb begin
        ext_a = {1'b0, a};
        ext_b = {1'b0, b};
        ext_c = {{W{1'b0}}, cin};
        if (sub)
            wide = ext_a - ext_b - ext_c;
        else
            wide = ext_a + ext_b + ext_c;
        res  = wide[W-1:0];
        mix  = a ^ b ^ wide[W-1:0];
        zero = ~|wide[W-1:0];
        sign = ~zero & wide[MSB];
        if (sub)
            ovf = (a[MSB] ^ wide[MSB]) & (a[MSB] ^ b[MSB]);
        else
            ovf = (wide[MSB] ^ a[MSB]) & (wide[MSB] ^ b[MSB]);
        flags = make_flags(sign, zero, mix[HB], ovf, sub, wide[W]);
    end

endmodule

// File: rtl/byte_negate.sv
module byte_negate
    import cc_flag_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] res,
    output flags_t       flags
);
    localparam int MSB = W - 1;
    localparam int HB  = 4;

    logic [W-1:0] diff;
    logic [W-1:0] mix;

    always_comb begin
        diff  = '0 - a;
        res   = diff;
        mix   = diff ^ a;
        flags = make_flags(diff[MSB], ~|diff, mix[HB], diff[MSB] & a[MSB], 1'b1, |a);
    end

endmodule

// File: rtl/cc_flag_unit.sv
module cc_flag_unit
    import cc_flag_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [1:0]          op,
    input  logic [WIDE_W-1:0]   acc_wide,
    input  logic [WIDE_W-1:0]   opnd_wide,
    input  logic [NARROW_W-1:0] acc_narrow,
    input  logic [7:0]          flags_in,
    output logic [WIDE_W-1:0]   res_wide,
    output logic [NARROW_W-1:0] res_narrow,
    output logic [7:0]          flags_out,
    output logic                done
);
    op_e                 op_sel;
    logic [WIDE_W-1:0]   as_res;
    flags_t              as_flags;
    logic [NARROW_W-1:0] ng_res;
    flags_t              ng_flags;

    logic [WIDE_W-1:0]   wide_nx;
    logic [NARROW_W-1:0] narrow_nx;
    flags_t              flags_nx;

    assign op_sel = op_e'(op);

    wide_addsub #(.W(WIDE_W)) u_addsub (
        .sub   (op_sel == OP_SBC),
        .a     (acc_wide),
        .b     (opnd_wide),
        .cin   (flags_in[FLAG_C]),
        .res   (as_res),
        .flags (as_flags)
    );

    byte_negate #(.W(NARROW_W)) u_negate (
        .a     (acc_narrow),
        .res   (ng_res),
        .flags (ng_flags)
    );

    always_comb begin
        wide_nx   = acc_wide;
        narrow_nx = acc_narrow;
        flags_nx  = clean_flags(flags_in);
        unique case (op_sel)
            OP_ADC, OP_SBC: begin
                wide_nx  = as_res;
                flags_nx = as_flags;
            end
            OP_NEG: begin
                narrow_nx = ng_res;
                flags_nx  = ng_flags;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_wide   <= '0;
            res_narrow <= '0;
            flags_out  <= '0;
            done       <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                res_wide   <= wide_nx;
                res_narrow <= narrow_nx;
                flags_out  <= flags_nx;
            end
        end
    end

    // R10: a strobe yields done on the next cycle
    a_r10_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R10 / R11: no strobe, no done
    a_r11_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R11: outputs hold while idle
    a_r11_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(res_wide) && $stable(res_narrow) && $stable(flags_out)));

    // R7: negate and subtract set the subtract flag, add clears it
    a_r7_subtract_flag: assert property (@(posedge clk) disable iff (rst)
        (start && (op == 2'd1 || op == 2'd2)) |=> flags_out[FLAG_N]);

    a_r7_add_clears_n: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd0) |=> !flags_out[FLAG_N]);

    // R8: negate carry set exactly when result is non-zero
    a_r8_neg_carry: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd2) |=> (flags_out[FLAG_C] == (res_narrow != '0)));

    // R9: unused flag bits stay clear
    a_r9_spare_bits_zero: assert property (@(posedge clk) disable iff (rst)
        done |-> (!flags_out[FLAG_X3] && !flags_out[FLAG_X5]));

endmodule

// File: tb/cc_flag_unit_tb.sv
module cc_flag_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [15:0] acc_wide = '0;
    logic [15:0] opnd_wide = '0;
    logic [7:0]  acc_narrow = '0;
    logic [7:0]  flags_in = '0;
    logic [15:0] res_wide;
    logic [7:0]  res_narrow;
    logic [7:0]  flags_out;
    logic        done;

    always #10 clk = ~clk;

    cc_flag_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .acc_wide(acc_wide), .opnd_wide(opnd_wide), .acc_narrow(acc_narrow),
        .flags_in(flags_in), .res_wide(res_wide), .res_narrow(res_narrow),
        .flags_out(flags_out), .done(done)
    );

    typedef struct {
        int    r16;
        int    r8;
        int    fl;
        string rtag;
        string ftag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   last16 = 0, last8 = 0, lastfl = 0;
    bit   mon_on = 0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    function automatic int sx16(input int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    function automatic exp_t model(input int o, input int a, input int b, input int a8, input int fi);
        exp_t e;
        int cin, full, low, s, z, h, v, n, c, sres;
        cin = fi & 1;
        e.r16 = a; e.r8 = a8;
        if (o == 0 || o == 1) begin
            if (o == 0) begin
                full = a + b + cin;
                c = (full > 65535) ? 1 : 0;
                sres = sx16(a) + sx16(b) + cin;
            end else begin
                full = a - b - cin;
                c = (full < 0) ? 1 : 0;
                sres = sx16(a) - sx16(b) - cin;
            end
            low = full & 16'hFFFF;
            z = (low == 0) ? 1 : 0;
            s = (z == 0 && ((low >> 15) & 1) == 1) ? 1 : 0;
            h = ((a ^ b ^ full) >> 12) & 1;
            v = (sres > 32767 || sres < -32768) ? 1 : 0;
            n = o;
            e.r16 = low;
            e.rtag = (o == 0) ? "R1" : "R2";
            e.ftag = "R3/R4/R5/R6/R7";
            e.fl = (s << 7) | (z << 6) | (h << 4) | (v << 2) | (n << 1) | c;
        end else if (o == 2) begin
            low = (256 - a8) & 8'hFF;
            s = (low >> 7) & 1;
            z = (low == 0) ? 1 : 0;
            h = ((a8 & 8'h0F) != 0) ? 1 : 0;
            v = (a8 == 8'h80) ? 1 : 0;
            c = (a8 != 0) ? 1 : 0;
            e.r8 = low;
            e.rtag = "R8";
            e.ftag = "R8/R7";
            e.fl = (s << 7) | (z << 6) | (h << 4) | (v << 2) | 2 | c;
        end else begin
            e.rtag = "R12";
            e.ftag = "R12";
            e.fl = fi & 8'hD7;
        end
        return e;
    endfunction

    task automatic issue(input int o, input int a, input int b, input int a8, input int fi);
        @(negedge clk);
        op = o[1:0]; acc_wide = a[15:0]; opnd_wide = b[15:0];
        acc_narrow = a8[7:0]; flags_in = fi[7:0]; start = 1'b1;
        q.push_back(model(o, a, b, a8, fi));
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            start = 1'b0;
            acc_wide = $urandom(); opnd_wide = $urandom();
            acc_narrow = $urandom(); flags_in = $urandom(); op = $urandom();
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R10 done without pending op", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(res_wide == e.r16[15:0], e.rtag, res_wide, e.r16);
                    check(res_narrow == e.r8[7:0], e.rtag, res_narrow, e.r8);
                    check(flags_out == e.fl[7:0], e.ftag, flags_out, e.fl);
                    check((flags_out & 8'h28) == 0, "R9", flags_out & 8'h28, 0);
                    last16 = e.r16; last8 = e.r8; lastfl = e.fl;
                end
            end else begin
                check(res_wide == last16[15:0] && res_narrow == last8[7:0] &&
                      flags_out == lastfl[7:0], "R11 hold",
                      {res_wide, res_narrow}, {last16[15:0], last8[7:0]});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        int corners[5];
        int bcorn[6];
        corners = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
        bcorn   = '{8'h00, 8'h80, 8'h7F, 8'hFF, 8'h01, 8'h10};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(res_wide == 0 && res_narrow == 0 && flags_out == 0 && done == 0,
              "R10 reset", {res_wide, res_narrow, flags_out}, 0);
        mon_on = 1;

        // Directed corners for add and subtract, both carry-in values
        for (int o = 0; o < 2; o++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int ci = 0; ci < 2; ci++)
                        issue(o, corners[i], corners[j], 8'h5A, ci | 8'hA8);
        idle(2);
        // R6/R4: 0x8000 + 0x8000 wraps to zero with overflow, no sign
        issue(0, 16'h8000, 16'h8000, 0, 0);
        // R5: half-carry out of bit 11
        issue(0, 16'h0800, 16'h0800, 0, 0);
        issue(1, 16'h1000, 16'h0001, 0, 0);
        idle(1);
        // R8: negate corners
        for (int i = 0; i < 6; i++) issue(2, 16'h1234, 0, bcorn[i], 8'hFF);
        // R12: pass op
        issue(3, 16'hBEEF, 16'h0, 8'hC3, 8'hFF);
        issue(3, 16'h0001, 16'h0, 8'h00, 8'h28);
        idle(3);

        // Random traffic, back-to-back and with gaps
        for (int k = 0; k < 1200; k++) begin
            issue($urandom_range(0, 3), $urandom_range(0, 65535), $urandom_range(0, 65535),
                  $urandom_range(0, 255), $urandom_range(0, 255));
            if ((k % 7) == 3) idle($urandom_range(1, 3));
        end
        idle(4);
        check(q.size() == 0, "R10 all ops completed", q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule